// File: doc/BRIEF.md
# Full-Format Indexed Address Unit

This unit resolves the effective address for the extended index extension word of a 32-bit CISC core. The core hands it a base value (an address register or the program counter), an index value already sign-extended to 32 bits, the 16-bit extension word and the program counter that points just past that word. The unit then works through a fixed sequence. It fetches an optional base displacement from the instruction stream, then an optional outer displacement, then makes an optional 32-bit memory-indirect pointer read. It returns the final effective address and the advanced program counter.

All data flows use valid/ready handshakes. A start is accepted on the cycle where `start_valid_i` and `start_ready_o` are both high, and `start_ready_o` is high only while the unit is idle. Each fetch or read request stays asserted with a stable address until its ready input is high. The request is accepted on that cycle, and exactly one response (`*_rvalid_i`) follows on some later cycle. There is never more than one request outstanding. The result is held on the output, stable, until `res_ready_i` is high. The consumer may stall the result for any number of cycles.

When the word is not in the extended format, the unit fetches nothing and returns a result with a flag set, so that the core can take its brief-format path instead. An instruction-stream fetch that would start at an odd address aborts the sequence with an alignment error. A fetch response that reports a fault aborts it with a bus error.

Top module: `fidx_agu`

## Requirements
- R1: After reset, `start_ready_o` is 1 and `res_valid_o`, `fetch_valid_o` and `rd_valid_o` are 0. While a start is being processed or a result is pending, `start_ready_o` is 0.
- R2: The extended format is used only when ext bit 8 is 1 and `wide_mode_i` is 1. Otherwise the result has `brief_o`=1, `err_code_o`=0 and `ea_o`=0, `pc_o` equals the start PC, and no fetch or read is issued.
- R3: Ext bit 7 = 1 replaces the base with 0. Ext bit 6 = 1 replaces the scaled index with 0.
- R4: The index is shifted left by ext bits 10..9 (0 to 3 places), wrapping modulo 2^32.
- R5: Ext bits 5..4 give the base displacement size, with the code 00 or 01 meaning none, 10 meaning word and 11 meaning long. A word fetch has `fetch_long_o`=0, its low 16 data bits are sign-extended, and it advances the PC by 2. A long fetch has `fetch_long_o`=1 and advances the PC by 4.
- R6: With ext bits 2..0 = 000, the result is base + base displacement + index, and no data read is issued.
- R7: With ext bits 2..0 nonzero and bit 2 = 0 (pre-indexed), the pointer is read at base + base displacement + index. The result is pointer + outer displacement, whose size is coded in ext bits 1..0 in the same way as R5.
- R8: With ext bit 2 = 1 (post-indexed), the pointer is read at base + base displacement. The result is pointer + index + outer displacement.
- R9: The requests come in this order: base displacement fetch at the start PC, then outer displacement fetch at the advanced PC, then the pointer read. No two requests are ever valid in the same cycle.
- R10: If the PC is odd when a fetch is due, `err_code_o`=1, no fetch is issued and `pc_o` is that PC. An odd PC with no fetch due is not an error.
- R11: A fetch response with `fetch_fault_i`=1 ends the sequence with `err_code_o`=2, and no further request is issued. `pc_o` keeps the PC of the faulting fetch.
- R12: A request held without ready keeps its address and size stable, and a result held without `res_ready_i` keeps all result fields stable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_valid_i | input | 1 | Start request valid |
| start_ready_o | output | 1 | Unit idle, start can be accepted |
| base_i | input | 32 | Base value (address register or PC) |
| index_i | input | 32 | Sign-extended index value before scaling |
| ext_i | input | 16 | Extension word |
| pc_i | input | 32 | PC of the next instruction-stream word |
| wide_mode_i | input | 1 | 32-bit core mode enables the extended format |
| fetch_valid_o | output | 1 | Instruction-stream fetch request |
| fetch_ready_i | input | 1 | Fetch request accepted |
| fetch_addr_o | output | 32 | Fetch address |
| fetch_long_o | output | 1 | 1 = 32-bit fetch, 0 = 16-bit fetch |
| fetch_rvalid_i | input | 1 | Fetch response valid |
| fetch_rdata_i | input | 32 | Fetch data (word in bits 15..0) |
| fetch_fault_i | input | 1 | Fetch response reports a bus fault |
| rd_valid_o | output | 1 | Pointer read request |
| rd_ready_i | input | 1 | Pointer read accepted |
| rd_addr_o | output | 32 | Pointer read address |
| rd_rvalid_i | input | 1 | Pointer read response valid |
| rd_rdata_i | input | 32 | Pointer value |
| res_valid_o | output | 1 | Result valid |
| res_ready_i | input | 1 | Result consumed |
| ea_o | output | 32 | Effective address (0 on error or brief) |
| pc_o | output | 32 | PC after the fetches |
| err_code_o | output | 2 | 0 none, 1 alignment error, 2 bus error |
| brief_o | output | 1 | Word is not in the extended format |

## Verification
A wrong sequencing state shows up at the request ports within a cycle or two of the step where it goes wrong. It appears as a request with the wrong size, an outer displacement fetched at the start PC, or a pointer read that is missing or extra. The bench checks this by recording every accepted request. Errors in the displacement, suppression or scaling paths show only when the result comes out, as a wrong `ea_o`, `rd_addr_o` or `pc_o`. Each scenario is therefore built so that every term it uses gives a distinct value in the expected sum. A state lost during an error or a stall appears as a result that changes or is released while `res_ready_i` is low, or as a request after a fault.

// File: rtl/fidx_pkg.sv
package fidx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH_BD,
    ST_FETCH_OD,
    ST_READ_IND,
    ST_DONE,
    ST_ERR
  } fidx_state_e;

  typedef enum logic [1:0] {
    DSZ_NONE = 2'd0,
    DSZ_WORD = 2'd1,
    DSZ_LONG = 2'd2
  } dsz_e;

  typedef enum logic [1:0] {
    ERR_NONE  = 2'd0,
    ERR_ALIGN = 2'd1,
    ERR_BUS   = 2'd2
  } err_e;

  typedef struct packed {
    logic       full;
    logic       base_sup;
    logic       idx_sup;
    logic [1:0] scale;
    dsz_e       bd_sz;
    dsz_e       od_sz;
    logic       indirect;
    logic       post;
  } ext_cfg_t;

  function automatic dsz_e size_code(input logic [1:0] f);
    case (f)
      2'b10:   return DSZ_WORD;
      2'b11:   return DSZ_LONG;
      default: return DSZ_NONE;
    endcase
  endfunction

  // step taken once the base displacement (if any) is in
  function automatic fidx_state_e after_bd(input ext_cfg_t c);
    if (c.indirect && c.od_sz != DSZ_NONE) return ST_FETCH_OD;
    if (c.indirect)                        return ST_READ_IND;
    return ST_DONE;
  endfunction

  // first step after a start is accepted
  function automatic fidx_state_e after_start(input ext_cfg_t c);
    if (!c.full)              return ST_DONE;
    if (c.bd_sz != DSZ_NONE)  return ST_FETCH_BD;
    return after_bd(c);
  endfunction

endpackage

// File: rtl/fidx_decode.sv
module fidx_decode
  import fidx_pkg::*;
#(
  parameter int EXT_W = 16
) (
  input  logic [EXT_W-1:0] ext_i,
  input  logic             wide_i,
  output ext_cfg_t         cfg_o
);

  localparam int FULL_BIT  = 8;
  localparam int BSUP_BIT  = 7;
  localparam int ISUP_BIT  = 6;
  localparam int BD_LSB    = 4;
  localparam int SCALE_LSB = 9;
  localparam int POST_BIT  = 2;

  always_comb begin
    cfg_o          = '0;
    cfg_o.full     = ext_i[FULL_BIT] & wide_i;
    cfg_o.base_sup = ext_i[BSUP_BIT];
    cfg_o.idx_sup  = ext_i[ISUP_BIT];
    cfg_o.scale    = ext_i[SCALE_LSB +: 2];
    cfg_o.bd_sz    = size_code(ext_i[BD_LSB +: 2]);
    cfg_o.indirect = |ext_i[POST_BIT:0];
    cfg_o.post     = ext_i[POST_BIT];
    cfg_o.od_sz    = cfg_o.indirect ? size_code(ext_i[1:0]) : DSZ_NONE;
  end

endmodule

// File: rtl/fidx_calc.sv
module fidx_calc #(
  parameter int AW      = 32,
  parameter int SCALE_N = 4,
  localparam int SW     = $clog2(SCALE_N)
) (
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] idx_i,
  input  logic [AW-1:0] bd_i,
  input  logic [AW-1:0] od_i,
  input  logic [AW-1:0] ptr_i,
  input  logic          base_sup_i,
  input  logic          idx_sup_i,
  input  logic          indirect_i,
  input  logic          post_i,
  input  logic [SW-1:0] scale_i,
  output logic [AW-1:0] ptr_addr_o,
  output logic [AW-1:0] ea_o
);

  logic [AW-1:0] shifted [SCALE_N];
  logic [AW-1:0] base_eff;
  logic [AW-1:0] idx_eff;
  logic [AW-1:0] inner;

  for (genvar g = 0; g < SCALE_N; g++) begin : g_scale
    assign shifted[g] = idx_i << g;
  end

  always_comb begin
    base_eff   = base_sup_i ? '0 : base_i;
    idx_eff    = idx_sup_i ? '0 : shifted[scale_i];
    inner      = base_eff + bd_i;
    ptr_addr_o = post_i ? inner : inner + idx_eff;
    if (!indirect_i)  ea_o = inner + idx_eff;
    else if (post_i)  ea_o = ptr_i + idx_eff + od_i;
    else              ea_o = ptr_i + od_i;
  end

endmodule

// File: rtl/fidx_ctrl.sv
module fidx_ctrl
  import fidx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start_valid_i,
  input  ext_cfg_t cfg_in_i,
  input  ext_cfg_t cfg_q_i,
  input  logic     pc_odd_i,
  input  logic     fetch_ready_i,
  input  logic     fetch_rvalid_i,
  input  logic     fetch_fault_i,
  input  logic     rd_ready_i,
  input  logic     rd_rvalid_i,
  input  logic     res_ready_i,
  output logic     start_ready_o,
  output logic     fetch_valid_o,
  output logic     fetch_long_o,
  output logic     rd_valid_o,
  output logic     res_valid_o,
  output logic     ld_start_o,
  output logic     ld_bd_o,
  output logic     ld_od_o,
  output logic     ld_ptr_o,
  output logic     brief_o,
  output err_e     err_o
);

  fidx_state_e state_q;
  logic        wait_q;
  logic        brief_q;
  err_e        err_q;
  logic        in_fetch;
  logic        fetch_ok;
  dsz_e        cur_sz;

  always_comb begin
    in_fetch      = (state_q == ST_FETCH_BD) || (state_q == ST_FETCH_OD);
    cur_sz        = (state_q == ST_FETCH_BD) ? cfg_q_i.bd_sz : cfg_q_i.od_sz;
    start_ready_o = (state_q == ST_IDLE);
    res_valid_o   = (state_q == ST_DONE) || (state_q == ST_ERR);
    fetch_valid_o = in_fetch && !wait_q && !pc_odd_i;
    fetch_long_o  = (cur_sz == DSZ_LONG);
    rd_valid_o    = (state_q == ST_READ_IND) && !wait_q;
    ld_start_o    = start_ready_o && start_valid_i;
    fetch_ok      = in_fetch && wait_q && fetch_rvalid_i && !fetch_fault_i;
    ld_bd_o       = fetch_ok && (state_q == ST_FETCH_BD);
    ld_od_o       = fetch_ok && (state_q == ST_FETCH_OD);
    ld_ptr_o      = (state_q == ST_READ_IND) && wait_q && rd_rvalid_i;
    brief_o       = brief_q;
    err_o         = err_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wait_q  <= 1'b0;
      brief_q <= 1'b0;
      err_q   <= ERR_NONE;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_valid_i) begin
            brief_q <= !cfg_in_i.full;
            err_q   <= ERR_NONE;
            wait_q  <= 1'b0;
            state_q <= after_start(cfg_in_i);
          end
        end
        ST_FETCH_BD, ST_FETCH_OD: begin
          if (!wait_q) begin
            if (pc_odd_i) begin
              err_q   <= ERR_ALIGN;
              state_q <= ST_ERR;
            end else if (fetch_ready_i) begin
              wait_q <= 1'b1;
            end
          end else if (fetch_rvalid_i) begin
            wait_q <= 1'b0;
            if (fetch_fault_i) begin
              err_q   <= ERR_BUS;
              state_q <= ST_ERR;
            end else if (state_q == ST_FETCH_BD) begin
              state_q <= after_bd(cfg_q_i);
            end else begin
              state_q <= ST_READ_IND;
            end
          end
        end
        ST_READ_IND: begin
          if (!wait_q) begin
            if (rd_ready_i) wait_q <= 1'b1;
          end else if (rd_rvalid_i) begin
            wait_q  <= 1'b0;
            state_q <= ST_DONE;
          end
        end
        ST_DONE, ST_ERR: begin
          if (res_ready_i) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fidx_agu.sv
module fidx_agu
  import fidx_pkg::*;
#(
  parameter int AW      = 32,
  parameter int EXT_W   = 16,
  parameter int WORD_W  = 16,
  parameter int SCALE_N = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_valid_i,
  output logic             start_ready_o,
  input  logic [AW-1:0]    base_i,
  input  logic [AW-1:0]    index_i,
  input  logic [EXT_W-1:0] ext_i,
  input  logic [AW-1:0]    pc_i,
  input  logic             wide_mode_i,
  output logic             fetch_valid_o,
  input  logic             fetch_ready_i,
  output logic [AW-1:0]    fetch_addr_o,
  output logic             fetch_long_o,
  input  logic             fetch_rvalid_i,
  input  logic [AW-1:0]    fetch_rdata_i,
  input  logic             fetch_fault_i,
  output logic             rd_valid_o,
  input  logic             rd_ready_i,
  output logic [AW-1:0]    rd_addr_o,
  input  logic             rd_rvalid_i,
  input  logic [AW-1:0]    rd_rdata_i,
  output logic             res_valid_o,
  input  logic             res_ready_i,
  output logic [AW-1:0]    ea_o,
  output logic [AW-1:0]    pc_o,
  output logic [1:0]       err_code_o,
  output logic             brief_o
);

  localparam int LONG_BYTES = AW / 8;
  localparam int WORD_BYTES = WORD_W / 8;

  ext_cfg_t      cfg_in;
  ext_cfg_t      cfg_q;
  logic [AW-1:0] base_q, idx_q, bd_q, od_q, ptr_q, pc_q;
  logic [AW-1:0] disp_val, pc_step;
  logic [AW-1:0] ptr_addr, final_ea;
  logic          ld_start, ld_bd, ld_od, ld_ptr;
  err_e          err_w;

  fidx_decode #(.EXT_W(EXT_W)) u_decode (
    .ext_i  (ext_i),
    .wide_i (wide_mode_i),
    .cfg_o  (cfg_in)
  );

  fidx_ctrl u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_valid_i  (start_valid_i),
    .cfg_in_i       (cfg_in),
    .cfg_q_i        (cfg_q),
    .pc_odd_i       (pc_q[0]),
    .fetch_ready_i  (fetch_ready_i),
    .fetch_rvalid_i (fetch_rvalid_i),
    .fetch_fault_i  (fetch_fault_i),
    .rd_ready_i     (rd_ready_i),
    .rd_rvalid_i    (rd_rvalid_i),
    .res_ready_i    (res_ready_i),
    .start_ready_o  (start_ready_o),
    .fetch_valid_o  (fetch_valid_o),
    .fetch_long_o   (fetch_long_o),
    .rd_valid_o     (rd_valid_o),
    .res_valid_o    (res_valid_o),
    .ld_start_o     (ld_start),
    .ld_bd_o        (ld_bd),
    .ld_od_o        (ld_od),
    .ld_ptr_o       (ld_ptr),
    .brief_o        (brief_o),
    .err_o          (err_w)
  );

  fidx_calc #(.AW(AW), .SCALE_N(SCALE_N)) u_calc (
    .base_i     (base_q),
    .idx_i      (idx_q),
    .bd_i       (bd_q),
    .od_i       (od_q),
    .ptr_i      (ptr_q),
    .base_sup_i (cfg_q.base_sup),
    .idx_sup_i  (cfg_q.idx_sup),
    .indirect_i (cfg_q.indirect),
    .post_i     (cfg_q.post),
    .scale_i    (cfg_q.scale),
    .ptr_addr_o (ptr_addr),
    .ea_o       (final_ea)
  );

  always_comb begin
    disp_val = fetch_long_o ? fetch_rdata_i
                            : {{(AW-WORD_W){fetch_rdata_i[WORD_W-1]}}, fetch_rdata_i[WORD_W-1:0]};
    pc_step  = fetch_long_o ? AW'(LONG_BYTES) : AW'(WORD_BYTES);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      base_q <= '0;
      idx_q  <= '0;
      bd_q   <= '0;
      od_q   <= '0;
      ptr_q  <= '0;
      pc_q   <= '0;
    end else begin
      if (ld_start) begin
        cfg_q  <= cfg_in;
        base_q <= base_i;
        idx_q  <= index_i;
        pc_q   <= pc_i;
        bd_q   <= '0;
        od_q   <= '0;
        ptr_q  <= '0;
      end
      if (ld_bd) begin
        bd_q <= disp_val;
        pc_q <= pc_q + pc_step;
      end
      if (ld_od) begin
        od_q <= disp_val;
        pc_q <= pc_q + pc_step;
      end
      if (ld_ptr) ptr_q <= rd_rdata_i;
    end
  end

  assign fetch_addr_o = pc_q;
  assign rd_addr_o    = ptr_addr;
  assign pc_o         = pc_q;
  assign err_code_o   = err_w;
  assign ea_o         = (res_valid_o && err_w == ERR_NONE && !brief_o) ? final_ea : '0;

endmodule

// File: rtl/fidx_agu_chk.sv
module fidx_agu_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_ready_o,
  input logic          fetch_valid_o,
  input logic          fetch_ready_i,
  input logic [AW-1:0] fetch_addr_o,
  input logic          fetch_long_o,
  input logic          rd_valid_o,
  input logic          rd_ready_i,
  input logic [AW-1:0] rd_addr_o,
  input logic          res_valid_o,
  input logic          res_ready_i,
  input logic [AW-1:0] ea_o,
  input logic [AW-1:0] pc_o,
  input logic [1:0]    err_code_o,
  input logic          brief_o
);

  // R1: idle excludes any pending request or result
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    start_ready_o |-> !res_valid_o && !fetch_valid_o && !rd_valid_o);

  // R2: a brief-format result carries no error and no address
  a_r2_brief_clean: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o && brief_o |-> err_code_o == 2'd0 && ea_o == '0);

  // R9: never two requests at once
  a_r9_one_req: assert property (@(posedge clk) disable iff (!rst_n)
    !(fetch_valid_o && rd_valid_o));

  // R10: no fetch at an odd address
  a_r10_even_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid_o |-> !fetch_addr_o[0]);

  // R11: error codes stay within the defined set
  a_r11_code_range: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |-> err_code_o != 2'd3);

  // R12: stalled fetch request holds
  a_r12_fetch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid_o && !fetch_ready_i |=> fetch_valid_o && $stable(fetch_addr_o) && $stable(fetch_long_o));

  // R12: stalled pointer read holds
  a_r12_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o && !rd_ready_i |=> rd_valid_o && $stable(rd_addr_o));

  // R12: stalled result holds
  a_r12_res_hold: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o && !res_ready_i |=> res_valid_o && $stable(ea_o) && $stable(pc_o)
                                    && $stable(err_code_o) && $stable(brief_o));

endmodule

bind fidx_agu fidx_agu_chk #(.AW(AW)) chk_i (.*);

// File: tb/fidx_agu_tb_top.sv
`timescale 1ns/1ps
module fidx_agu_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_valid_i = 1'b0;
  logic        start_ready_o;
  logic [31:0] base_i = '0, index_i = '0, pc_i = '0;
  logic [15:0] ext_i = '0;
  logic        wide_mode_i = 1'b0;
  logic        fetch_valid_o, fetch_long_o;
  logic        fetch_ready_i, fetch_rvalid_i, fetch_fault_i;
  logic [31:0] fetch_addr_o, fetch_rdata_i;
  logic        rd_valid_o, rd_ready_i, rd_rvalid_i;
  logic [31:0] rd_addr_o, rd_rdata_i;
  logic        res_valid_o;
  logic        res_ready_i = 1'b1;
  logic [31:0] ea_o, pc_o;
  logic [1:0]  err_code_o;
  logic        brief_o;

  int n_chk = 0;
  int n_bad = 0;

  // responder state
  logic [31:0] fdata [4];
  logic [31:0] f_addr [4];
  logic        f_long [4];
  logic [31:0] mem_val;
  logic [31:0] r_addr_seen;
  int f_cnt, r_cnt, fault_at, f_stall, r_stall;
  logic f_pend = 1'b0, r_pend = 1'b0;

  // captured result
  logic [31:0] r_ea, r_pc;
  logic [1:0]  r_err;
  logic        r_brief;

  always #2.5 clk = ~clk;

  fidx_agu dut_i (
    .clk(clk), .rst_n(rst_n),
    .start_valid_i(start_valid_i), .start_ready_o(start_ready_o),
    .base_i(base_i), .index_i(index_i), .ext_i(ext_i), .pc_i(pc_i),
    .wide_mode_i(wide_mode_i),
    .fetch_valid_o(fetch_valid_o), .fetch_ready_i(fetch_ready_i),
    .fetch_addr_o(fetch_addr_o), .fetch_long_o(fetch_long_o),
    .fetch_rvalid_i(fetch_rvalid_i), .fetch_rdata_i(fetch_rdata_i),
    .fetch_fault_i(fetch_fault_i),
    .rd_valid_o(rd_valid_o), .rd_ready_i(rd_ready_i), .rd_addr_o(rd_addr_o),
    .rd_rvalid_i(rd_rvalid_i), .rd_rdata_i(rd_rdata_i),
    .res_valid_o(res_valid_o), .res_ready_i(res_ready_i),
    .ea_o(ea_o), .pc_o(pc_o), .err_code_o(err_code_o), .brief_o(brief_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // memory and instruction-stream responder, all changes at the falling edge
  initial begin
    fetch_ready_i = 1'b1; fetch_rvalid_i = 1'b0; fetch_fault_i = 1'b0; fetch_rdata_i = '0;
    rd_ready_i = 1'b1; rd_rvalid_i = 1'b0; rd_rdata_i = '0;
    f_cnt = 0; r_cnt = 0; fault_at = -1; f_stall = 0; r_stall = 0;
    forever begin
      @(negedge clk);
      fetch_rvalid_i = 1'b0; fetch_fault_i = 1'b0;
      rd_rvalid_i = 1'b0;
      if (f_pend) begin
        fetch_rvalid_i = 1'b1;
        fetch_rdata_i  = (f_cnt >= 1 && f_cnt <= 4) ? fdata[f_cnt-1] : 32'h0;
        fetch_fault_i  = (fault_at == f_cnt - 1);
        f_pend = 1'b0;
      end
      if (r_pend) begin
        rd_rvalid_i = 1'b1;
        rd_rdata_i  = mem_val;
        r_pend = 1'b0;
      end
      fetch_ready_i = (f_stall == 0);
      rd_ready_i    = (r_stall == 0);
      if (fetch_valid_o) begin
        if (fetch_ready_i) begin
          if (f_cnt < 4) begin
            f_addr[f_cnt] = fetch_addr_o;
            f_long[f_cnt] = fetch_long_o;
          end
          f_cnt++;
          f_pend = 1'b1;
        end else f_stall--;
      end
      if (rd_valid_o) begin
        if (rd_ready_i) begin
          r_addr_seen = rd_addr_o;
          r_cnt++;
          r_pend = 1'b1;
        end else r_stall--;
      end
    end
  end

  task automatic run(input logic [31:0] b, input logic [31:0] x, input logic [31:0] p,
                     input logic [15:0] e, input logic w);
    int tmo;
    @(negedge clk);
    f_cnt = 0; r_cnt = 0;
    base_i = b; index_i = x; pc_i = p; ext_i = e; wide_mode_i = w;
    start_valid_i = 1'b1;
    @(negedge clk);
    start_valid_i = 1'b0;
    tmo = 0;
    while (!res_valid_o && tmo < 1000) begin
      @(negedge clk);
      tmo++;
    end
    r_ea = ea_o; r_pc = pc_o; r_err = err_code_o; r_brief = brief_o;
    if (res_ready_i) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 start_ready after reset", 32'(start_ready_o), 32'd1);
    chk("R1 res_valid after reset", 32'(res_valid_o), 32'd0);
    chk("R1 no request after reset", 32'(fetch_valid_o | rd_valid_o), 32'd0);
  endtask

  task automatic t_brief;
    fdata[0] = 32'h1111_2222;
    run(32'h1000, 32'h4, 32'h0200, 16'h0020, 1'b1);   // bit 8 clear
    chk("R2 brief flag bit8=0", 32'(r_brief), 32'd1);
    chk("R2 no fetch bit8=0", 32'(f_cnt), 32'd0);
    chk("R2 pc unchanged", r_pc, 32'h0200);
    chk("R2 ea zero", r_ea, 32'h0);
    run(32'h1000, 32'h4, 32'h0210, 16'h0520, 1'b0);   // narrow mode
    chk("R2 brief flag narrow", 32'(r_brief), 32'd1);
    chk("R2 no fetch narrow", 32'(f_cnt + r_cnt), 32'd0);
    chk("R2 err none", 32'(r_err), 32'd0);
  endtask

  task automatic t_direct_word;
    fdata[0] = 32'hABCD_FFF0;                        // word -16, junk above
    run(32'h1000, 32'h10, 32'h0200, 16'h0520, 1'b1); // bd word, scale x4
    chk("R6 R4 R5 ea base+sext(bd)+idx<<2", r_ea, 32'h0000_1030);
    chk("R5 pc +2", r_pc, 32'h0202);
    chk("R5 word size", 32'(f_long[0]), 32'd0);
    chk("R6 no pointer read", 32'(r_cnt), 32'd0);
    chk("R9 bd at start pc", f_addr[0], 32'h0200);
  endtask

  task automatic t_suppress_long;
    fdata[0] = 32'h1234_5678;
    run(32'h1000, 32'h5, 32'h0300, 16'h01F0, 1'b1);  // both suppressed, bd long
    chk("R3 ea equals bd only", r_ea, 32'h1234_5678);
    chk("R5 pc +4", r_pc, 32'h0304);
    chk("R5 long size", 32'(f_long[0]), 32'd1);
  endtask

  task automatic t_pre_indexed;
    fdata[0] = 32'h0000_0010; fdata[1] = 32'h0000_0100; mem_val = 32'h4000_0000;
    run(32'h2000, 32'h8, 32'h0400, 16'h0123, 1'b1);
    chk("R7 read addr base+bd+idx", r_addr_seen, 32'h0000_2018);
    chk("R7 ea ptr+od", r_ea, 32'h4000_0100);
    chk("R9 od after bd", f_addr[1], 32'h0402);
    chk("R9 od long", 32'(f_long[1]), 32'd1);
    chk("R9 one read", 32'(r_cnt), 32'd1);
    chk("R5 pc +2+4", r_pc, 32'h0406);
  endtask

  task automatic t_post_indexed;
    fdata[0] = 32'h7777_FFFE; mem_val = 32'h0000_5000;  // od word -2
    run(32'h3000, 32'h10, 32'h0500, 16'h0316, 1'b1);     // null bd, scale x2
    chk("R8 read addr base+bd", r_addr_seen, 32'h0000_3000);
    chk("R8 ea ptr+idx+od", r_ea, 32'h0000_501E);
    chk("R5 null bd code 01 one fetch", 32'(f_cnt), 32'd1);
    chk("R8 od fetch at start pc", f_addr[0], 32'h0500);
    mem_val = 32'h0000_6000;
    run(32'h3100, 32'h4, 32'h0510, 16'h0104, 1'b1);     // post, null od
    chk("R8 null od no fetch", 32'(f_cnt), 32'd0);
    chk("R8 ea ptr+idx", r_ea, 32'h0000_6004);
    chk("R8 pc unchanged", r_pc, 32'h0510);
  endtask

  task automatic t_scale_wrap;
    run(32'h0, 32'h8000_0001, 32'h0600, 16'h0700, 1'b1);
    chk("R4 shift by 3 wraps", r_ea, 32'h0000_0008);
  endtask

  task automatic t_align;
    run(32'h100, 32'h1, 32'h0601, 16'h0120, 1'b1);
    chk("R10 alignment error code", 32'(r_err), 32'd1);
    chk("R10 no fetch issued", 32'(f_cnt), 32'd0);
    chk("R10 pc kept", r_pc, 32'h0601);
    run(32'h10, 32'h1, 32'h0701, 16'h0100, 1'b1);
    chk("R10 odd pc without fetch no error", 32'(r_err), 32'd0);
    chk("R10 odd pc without fetch ea", r_ea, 32'h11);
  endtask

  task automatic t_bus_fault;
    fdata[0] = 32'h0000_0004; fdata[1] = 32'h0000_0008; mem_val = 32'h0;
    fault_at = 1;
    run(32'h100, 32'h1, 32'h0800, 16'h0122, 1'b1);
    fault_at = -1;
    chk("R11 bus error code", 32'(r_err), 32'd2);
    chk("R11 no pointer read", 32'(r_cnt), 32'd0);
    chk("R11 pc of faulting fetch", r_pc, 32'h0802);
    chk("R11 ea zero on error", r_ea, 32'h0);
  endtask

  task automatic t_backpressure;
    fdata[0] = 32'h0000_0010; fdata[1] = 32'h0000_0100; mem_val = 32'h4000_0000;
    f_stall = 3; r_stall = 2;
    res_ready_i = 1'b0;
    run(32'h2000, 32'h8, 32'h0900, 16'h0123, 1'b1);
    chk("R12 stalled fetch addr", f_addr[0], 32'h0900);
    chk("R12 stalled read addr", r_addr_seen, 32'h0000_2018);
    repeat (3) @(negedge clk);
    chk("R12 result held valid", 32'(res_valid_o), 32'd1);
    chk("R12 result stable", ea_o, r_ea);
    chk("R12 ea value", r_ea, 32'h4000_0100);
    chk("R1 start_ready low while result pending", 32'(start_ready_o), 32'd0);
    res_ready_i = 1'b1;
    @(negedge clk);
    chk("R12 result released", 32'(res_valid_o), 32'd0);
    chk("R1 idle again", 32'(start_ready_o), 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R9 watchdog act=running exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_brief();
    t_direct_word();
    t_suppress_long();
    t_pre_indexed();
    t_post_indexed();
    t_scale_wrap();
    t_align();
    t_bus_fault();
    t_backpressure();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule